// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block is the counting heart of a real-time clock. A tick enable at 128 Hz advances a 7-bit sub-second counter. Each time that counter wraps, a chain of BCD counters moves forward by one second. The chain holds seconds, minutes, hours, day of week, day of month, month and a four-digit year. Month lengths follow the Gregorian leap rules, applied to the full year.

Software reaches every counter and both control words through a simple register port: a 4-bit index, a 16-bit write word and a combinational read word. The year is a 16-bit register. Every other counter uses the low byte.

To set the time, software:
1. Writes the second control word with the prescaler-reset bit set.
2. Loads the counters.
3. Writes the second control word again with reset clear and start set.

A carry flag is raised on every one-second carry. Software can clear it, read the counters, and then check whether it came back. If it did, the read straddled a rollover and should be repeated. An optional interrupt output follows the flag.

The run control is a three-state machine:
- ST_HALT: stopped.
- ST_RUN: counting.
- ST_HOLD: prescaler held in reset.

Every write to the second control word selects the next state:
- If the reset bit (bit 1) is 1, the next state is ST_HOLD, from any state.
- Otherwise, if the start bit (bit 0) is 1, the next state is ST_RUN.
- Otherwise, the next state is ST_HALT.

Without a write, the state is kept.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, the registers hold these values:
  - sub-second 0, seconds 00, minutes 00, hours 00, weekday 0
  - day 01, month 01, year 0x2000
  - both control words 0, carry interrupt low
- R2: Index map and widths:
  - Indices 0..7 are sub-second, seconds, minutes, hours, weekday, day, month and year. Each reads back what was written.
  - The year (index 7) uses all 16 bits: BCD century in bits 15:8, BCD year in bits 7:0.
  - The other counters use bits 7:0 and read 0 in bits 15:8.
  - Indices 8..13 read 0, and writes to them change nothing.
- R3: In ST_RUN, each tick enable adds 1 to the sub-second counter. The wrap from 127 to 0 advances seconds by one in the same cycle.
- R4: Time rollovers:
  - Seconds roll 59 to 00 and carry into minutes.
  - Minutes roll 59 to 00 and carry into hours.
  - Hours roll 23 to 00 and signal a day change.
  - On a day change, the weekday steps up, with 6 followed by 0.
- R5: Date rollovers:
  - On a day change, the day of month wraps to 01 after the month's last day. That last day is 28/29/30/31, with February 29 in years divisible by 4, except centuries not divisible by 400.
  - The month wraps 12 to 01 and increments the four-digit BCD year, carrying into the century.
- R6: Second control word (index 15):
  - Bit 0 is start, bit 1 is prescaler reset, bit 3 is enable. These select the states as described above.
  - Counting happens only in ST_RUN.
  - It reads back enable in bit 3, 1 in bit 1 while in ST_HOLD, and 1 in bit 0 while in ST_RUN. Bit 2 reads 0.
- R7: A write with bit 1 set clears the sub-second counter in that cycle. The counter then stays 0 while in ST_HOLD, even against ticks or writes to index 0.
- R8: The carry flag (index 14, bit 7) becomes 1 in the cycle after each sub-second-to-seconds carry.
- R9: Writing index 14:
  - Bit 4 is stored as the carry interrupt enable.
  - Writing 0 to bit 7 clears the flag; writing 1 leaves it unchanged.
  - A new carry in the same cycle as a clear leaves the flag set.
- R10: The carry interrupt output is 1 exactly while both the carry flag and the carry interrupt enable are 1.
- R11: A write to a counter wins over an increment in the same cycle. A counter being written does not pass a carry on to the next counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at 128 Hz that advances the sub-second counter |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 4 | Register index, used for both read and write |
| wr_data | input | 16 | Write word; byte registers take bits 7:0 |
| rd_data | output | 16 | Combinational read word of the register at `addr` |
| carry_irq | output | 1 | High while the carry flag and its enable are both set |

## Verification
The range properties on seconds and day assume software writes only legal BCD values, within each field's range. The stimulus therefore draws every written counter value from a legal range and converts it to BCD, and picks day values against the current month's length. A later month write may still leave the day beyond the new month's end. Both the design and the bench treat that case as the last day, wrapping to 01 at the next day change. The hold-clears and halt-freezes properties assume the control word is only written with the documented bit patterns. The random phase keeps to the three patterns that select halt, run and hold.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;
    localparam int NUM_TF = 3;   // seconds, minutes, hours

    localparam logic [ADDR_W-1:0] A_SUB  = 4'd0;
    localparam logic [ADDR_W-1:0] A_SEC  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MIN  = 4'd2;
    localparam logic [ADDR_W-1:0] A_HR   = 4'd3;
    localparam logic [ADDR_W-1:0] A_WK   = 4'd4;
    localparam logic [ADDR_W-1:0] A_DAY  = 4'd5;
    localparam logic [ADDR_W-1:0] A_MON  = 4'd6;
    localparam logic [ADDR_W-1:0] A_YR   = 4'd7;
    localparam logic [ADDR_W-1:0] A_CTL1 = 4'd14;
    localparam logic [ADDR_W-1:0] A_CTL2 = 4'd15;

    localparam int CF_BIT    = 7;
    localparam int CIE_BIT   = 4;
    localparam int EN_BIT    = 3;
    localparam int RST_BIT   = 1;
    localparam int START_BIT = 0;

    localparam logic [7:0] TF_MAX [NUM_TF] = '{8'h59, 8'h59, 8'h23};

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_t;

    function automatic logic [7:0] bcd8_inc(input logic [7:0] v);
        logic [7:0] r;
        logic       c;
        r = v;
        c = 1'b1;
        for (int i = 0; i < 2; i++) begin
            if (c) begin
                if (r[i*4 +: 4] >= 4'd9) r[i*4 +: 4] = 4'd0;
                else begin
                    r[i*4 +: 4] = r[i*4 +: 4] + 4'd1;
                    c = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [15:0] bcd16_inc(input logic [15:0] v);
        logic [15:0] r;
        logic        c;
        r = v;
        c = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (c) begin
                if (r[i*4 +: 4] >= 4'd9) r[i*4 +: 4] = 4'd0;
                else begin
                    r[i*4 +: 4] = r[i*4 +: 4] + 4'd1;
                    c = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic logic is_leap(input logic [15:0] y);
        logic [6:0] yy;
        logic [6:0] cc;
        yy = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        cc = 7'(y[15:12]) * 7'd10 + 7'(y[11:8]);
        return (yy[1:0] == 2'd0) && ((yy != 7'd0) || (cc[1:0] == 2'd0));
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [15:0] y);
        logic [7:0] r;
        case (mon)
            8'h02:                      r = is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_subsec_count.sv
`timescale 1ns/1ps
module rtc_subsec_count #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         carry
);
    // clear dominates load, load dominates increment
    assign carry = inc && !load && !clr && (&count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clr)   count <= '0;
        else if (load)  count <= load_val;
        else if (inc)   count <= count + W'(1);
    end
endmodule

// File: rtl/rtc_bcd_field.sv
`timescale 1ns/1ps
module rtc_bcd_field
    import rtc_cal_pkg::*;
#(
    parameter logic [7:0] RST_VAL = 8'h00,
    parameter logic [7:0] MIN_VAL = 8'h00,
    parameter logic [7:0] MAX_VAL = 8'h59
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       load,
    input  logic [7:0] load_val,
    output logic [7:0] value,
    output logic       wrap
);
    logic at_max;
    assign at_max = (value >= MAX_VAL);
    assign wrap   = inc && !load && at_max;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    value <= RST_VAL;
        else if (load) value <= load_val;
        else if (inc)  value <= at_max ? MIN_VAL : bcd8_inc(value);
    end
endmodule

// File: rtl/rtc_date_chain.sv
`timescale 1ns/1ps
module rtc_date_chain
    import rtc_cal_pkg::*;
#(
    parameter logic [15:0] RST_YEAR = 16'h2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inc_day,
    input  logic        ld_day,
    input  logic        ld_mon,
    input  logic        ld_yr,
    input  logic [15:0] wr_data,
    output logic [7:0]  day_q,
    output logic [7:0]  mon_q,
    output logic [15:0] yr_q
);
    logic [7:0] last_day;
    logic       day_wrap;
    logic       mon_wrap;

    assign last_day = month_len(mon_q, yr_q);
    assign day_wrap = inc_day && !ld_day && (day_q >= last_day);
    assign mon_wrap = day_wrap && !ld_mon && (mon_q >= 8'h12);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            day_q <= 8'h01;
            mon_q <= 8'h01;
            yr_q  <= RST_YEAR;
        end else begin
            if (ld_day)       day_q <= wr_data[7:0];
            else if (inc_day) day_q <= day_wrap ? 8'h01 : bcd8_inc(day_q);

            if (ld_mon)        mon_q <= wr_data[7:0];
            else if (day_wrap) mon_q <= (mon_q >= 8'h12) ? 8'h01 : bcd8_inc(mon_q);

            if (ld_yr)         yr_q <= wr_data;
            else if (mon_wrap) yr_q <= bcd16_inc(yr_q);
        end
    end
endmodule

// File: rtl/rtc_bcd_calendar.sv
`timescale 1ns/1ps
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
#(
    parameter int          SUB_W    = 7,
    parameter logic [15:0] RST_YEAR = 16'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              carry_irq
);
    run_state_t state_q, state_d;
    logic run, hold;
    logic wr_ctl1, wr_ctl2, ctl_reset, ctl_start;

    assign wr_ctl1   = wr_en && (addr == A_CTL1);
    assign wr_ctl2   = wr_en && (addr == A_CTL2);
    assign ctl_reset = wr_data[RST_BIT];
    assign ctl_start = wr_data[START_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (wr_ctl2 && ctl_reset)      state_d = ST_HOLD;
                else if (wr_ctl2 && ctl_start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (wr_ctl2 && ctl_reset)       state_d = ST_HOLD;
                else if (wr_ctl2 && !ctl_start) state_d = ST_HALT;
            end
            ST_HOLD: begin
                if (wr_ctl2 && !ctl_reset) state_d = ctl_start ? ST_RUN : ST_HALT;
            end
            default: state_d = ST_HALT;
        endcase
    end

    // state outputs
    always_comb begin
        run  = 1'b0;
        hold = 1'b0;
        unique case (state_q)
            ST_RUN:  run  = 1'b1;
            ST_HOLD: hold = 1'b1;
            default: ;
        endcase
    end

    // sub-second prescaler
    logic [SUB_W-1:0] sub_q;
    logic             one_sec;

    rtc_subsec_count #(.W(SUB_W)) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hold || (wr_ctl2 && ctl_reset)),
        .load     (wr_en && (addr == A_SUB)),
        .load_val (wr_data[SUB_W-1:0]),
        .inc      (run && tick_en),
        .count    (sub_q),
        .carry    (one_sec)
    );

    // seconds, minutes, hours
    logic [NUM_TF-1:0][7:0] tf_q;
    logic [NUM_TF-1:0]      tf_inc;
    logic [NUM_TF-1:0]      tf_wrap;

    for (genvar g = 0; g < NUM_TF; g++) begin : g_time
        if (g == 0) begin : g_first
            assign tf_inc[g] = one_sec;
        end else begin : g_next
            assign tf_inc[g] = tf_wrap[g-1];
        end
        rtc_bcd_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00), .MAX_VAL(TF_MAX[g])) u_field (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (tf_inc[g]),
            .load     (wr_en && (addr == ADDR_W'(A_SEC + ADDR_W'(g)))),
            .load_val (wr_data[7:0]),
            .value    (tf_q[g]),
            .wrap     (tf_wrap[g])
        );
    end

    logic       day_change;
    logic [7:0] wk_q;
    logic       wk_wrap;
    assign day_change = tf_wrap[NUM_TF-1];

    rtc_bcd_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00), .MAX_VAL(8'h06)) u_wday (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (day_change),
        .load     (wr_en && (addr == A_WK)),
        .load_val (wr_data[7:0]),
        .value    (wk_q),
        .wrap     (wk_wrap)
    );

    logic [7:0]  day_q, mon_q;
    logic [15:0] yr_q;

    rtc_date_chain #(.RST_YEAR(RST_YEAR)) u_date (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_day (day_change),
        .ld_day  (wr_en && (addr == A_DAY)),
        .ld_mon  (wr_en && (addr == A_MON)),
        .ld_yr   (wr_en && (addr == A_YR)),
        .wr_data (wr_data),
        .day_q   (day_q),
        .mon_q   (mon_q),
        .yr_q    (yr_q)
    );

    // control word 1 and enable bit of control word 2
    logic cf_q, cie_q, en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cf_q  <= 1'b0;
            cie_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            if (wr_ctl2) en_q  <= wr_data[EN_BIT];
            if (wr_ctl1) cie_q <= wr_data[CIE_BIT];
            if (one_sec)                          cf_q <= 1'b1;
            else if (wr_ctl1 && !wr_data[CF_BIT]) cf_q <= 1'b0;
        end
    end

    assign carry_irq = cf_q && cie_q;

    // read mux
    always_comb begin
        rd_data = '0;
        case (addr)
            A_SUB:  rd_data = REG_W'(sub_q);
            A_SEC:  rd_data = REG_W'(tf_q[0]);
            A_MIN:  rd_data = REG_W'(tf_q[1]);
            A_HR:   rd_data = REG_W'(tf_q[2]);
            A_WK:   rd_data = REG_W'(wk_q);
            A_DAY:  rd_data = REG_W'(day_q);
            A_MON:  rd_data = REG_W'(mon_q);
            A_YR:   rd_data = yr_q;
            A_CTL1: rd_data = REG_W'({cf_q, 2'b00, cie_q, 4'b0000});
            A_CTL2: rd_data = REG_W'({en_q, 1'b0, hold, run});
            default: rd_data = '0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = wk_wrap;
endmodule

// File: rtl/rtc_cal_checks.sv
`timescale 1ns/1ps
module rtc_cal_checks #(
    parameter int SUB_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       addr,
    input logic [15:0]      wr_data,
    input logic             run,
    input logic             hold,
    input logic [SUB_W-1:0] sub_q,
    input logic [7:0]       sec_q,
    input logic [7:0]       day_q,
    input logic             cf_q,
    input logic             one_sec
);
    // R11: a seconds write lands regardless of a concurrent increment
    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd1) |=> (sec_q == $past(wr_data[7:0])));

    // R7: the sub-second count stays zero while the prescaler is held
    p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (sub_q == '0));

    // R6: outside the counting state, with no write, nothing moves
    p_halt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> ($stable(sub_q) && $stable(sec_q)));

    // R8: every one-second carry raises the flag
    p_flag_on_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        one_sec |=> cf_q);

    // R9: writing 0 to the flag without a new carry clears it
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd14 && !wr_data[7] && !one_sec) |=> !cf_q);

    // R4: seconds remain legal BCD 00..59
    p_sec_bcd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q <= 8'h59) && (sec_q[3:0] <= 4'd9));

    // R5: day of month remains 01..31
    p_day_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (day_q >= 8'h01) && (day_q <= 8'h31));
endmodule

bind rtc_bcd_calendar rtc_cal_checks #(.SUB_W(SUB_W)) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .run     (run),
    .hold    (hold),
    .sub_q   (sub_q),
    .sec_q   (tf_q[0]),
    .day_q   (day_q),
    .cf_q    (cf_q),
    .one_sec (one_sec)
);

// File: tb/rtc_bcd_calendar_bench.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        carry_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_bcd_calendar u_rtc_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .carry_irq(carry_irq)
    );

    // reference model state (binary)
    int m_sub, m_sec, m_min, m_hr, m_wk, m_day, m_mon, m_yr, m_st;
    bit m_cf, m_cie, m_en;

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) % 10) * 16 + (v % 10));
    endfunction

    function automatic int unbcd(input logic [7:0] x);
        return int'(x[7:4]) * 10 + int'(x[3:0]);
    endfunction

    function automatic logic [15:0] yr_reg(input int y);
        return {bcd(y / 100), bcd(y % 100)};
    endfunction

    function automatic int dim(input int m, input int y);
        bit leap;
        leap = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        if (m == 2) return leap ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [15:0] exp_reg(input int a);
        case (a)
            0: return 16'(m_sub);
            1: return {8'h00, bcd(m_sec)};
            2: return {8'h00, bcd(m_min)};
            3: return {8'h00, bcd(m_hr)};
            4: return {8'h00, bcd(m_wk)};
            5: return {8'h00, bcd(m_day)};
            6: return {8'h00, bcd(m_mon)};
            7: return yr_reg(m_yr);
            14: return {8'h00, m_cf, 2'b00, m_cie, 4'b0000};
            15: return {8'h00, 4'b0000, m_en, 1'b0, (m_st == 2), (m_st == 1)};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_reset();
        m_sub = 0; m_sec = 0; m_min = 0; m_hr = 0; m_wk = 0;
        m_day = 1; m_mon = 1; m_yr = 2000; m_st = 0;
        m_cf = 0; m_cie = 0; m_en = 0;
    endtask

    task automatic model_step(input bit t, input bit w, input int a, input logic [15:0] d);
        bit sc, mc, hc, dc, moc, yc;
        bit run;
        sc = 0; mc = 0; hc = 0; dc = 0; moc = 0; yc = 0;
        run = (m_st == 1);
        if (m_st == 2 || (w && a == 15 && d[1])) m_sub = 0;
        else if (w && a == 0) m_sub = int'(d[6:0]);
        else if (run && t) begin
            if (m_sub == 127) begin m_sub = 0; sc = 1; end
            else m_sub++;
        end
        if (w && a == 1) m_sec = unbcd(d[7:0]);
        else if (sc) begin if (m_sec >= 59) begin m_sec = 0; mc = 1; end else m_sec++; end
        if (w && a == 2) m_min = unbcd(d[7:0]);
        else if (mc) begin if (m_min >= 59) begin m_min = 0; hc = 1; end else m_min++; end
        if (w && a == 3) m_hr = unbcd(d[7:0]);
        else if (hc) begin if (m_hr >= 23) begin m_hr = 0; dc = 1; end else m_hr++; end
        if (w && a == 4) m_wk = unbcd(d[7:0]);
        else if (dc) m_wk = (m_wk >= 6) ? 0 : m_wk + 1;
        if (w && a == 5) m_day = unbcd(d[7:0]);
        else if (dc) begin
            if (m_day >= dim(m_mon, m_yr)) begin m_day = 1; moc = 1; end else m_day++;
        end
        if (w && a == 6) m_mon = unbcd(d[7:0]);
        else if (moc) begin if (m_mon >= 12) begin m_mon = 1; yc = 1; end else m_mon++; end
        if (w && a == 7) m_yr = unbcd(d[15:8]) * 100 + unbcd(d[7:0]);
        else if (yc) m_yr = (m_yr + 1) % 10000;
        if (w && a == 14) begin m_cie = d[4]; if (!d[7]) m_cf = 0; end
        if (sc) m_cf = 1;
        if (w && a == 15) begin
            m_en = d[3];
            m_st = d[1] ? 2 : (d[0] ? 1 : 0);
        end
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit t, input bit w, input int a, input logic [15:0] d);
        @(negedge clk);
        tick_en = t; wr_en = w; addr = 4'(a); wr_data = d;
        @(posedge clk);
        model_step(t, w, a, d);
        #1;
        tick_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        addr = 4'(a);
        #1;
        v = rd_data;
    endtask

    task automatic compare_all(input string tag);
        logic [15:0] v;
        for (int a = 0; a < 16; a++) begin
            if (a < 8 || a >= 14) begin
                rd(a, v);
                check($sformatf("%s reg %0d", tag, a), v, exp_reg(a));
            end
        end
        check($sformatf("%s irq (R10)", tag), {15'd0, carry_irq}, {15'd0, m_cf & m_cie});
    endtask

    task automatic set_time(input int h, input int mi, input int s, input int wk,
                            input int dy, input int mo, input int y);
        cyc(0, 1, 15, 16'h0002);
        cyc(0, 1, 1, {8'h00, bcd(s)});
        cyc(0, 1, 2, {8'h00, bcd(mi)});
        cyc(0, 1, 3, {8'h00, bcd(h)});
        cyc(0, 1, 4, {8'h00, bcd(wk)});
        cyc(0, 1, 5, {8'h00, bcd(dy)});
        cyc(0, 1, 6, {8'h00, bcd(mo)});
        cyc(0, 1, 7, yr_reg(y));
        cyc(0, 1, 15, 16'h0009);
    endtask

    // day-change corner: 23:59:59.127 then one tick
    task automatic day_corner(input string tag, input int dy, input int mo, input int y,
                              input int edy, input int emo, input int ey);
        set_time(23, 59, 59, 6, dy, mo, y);
        cyc(0, 1, 0, 16'd127);
        cyc(1, 0, 0, 16'd0);
        compare_all(tag);
        check({tag, " day"}, {8'h00, bcd(m_day)}, {8'h00, bcd(edy)});
        check({tag, " month"}, {8'h00, bcd(m_mon)}, {8'h00, bcd(emo)});
        check({tag, " year"}, yr_reg(m_yr), yr_reg(ey));
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240229));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        compare_all("R1 reset");

        // R6: halted ticks do nothing
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 16'd0);
        compare_all("R6 halted");

        // R2: alarm window reads zero, writes ignored; year halfword
        cyc(0, 1, 9, 16'h0055);
        rd(9, v); check("R2 alarm index reads 0", v, 16'h0000);
        cyc(0, 1, 7, 16'h1999);
        compare_all("R2 year halfword");

        // R7: hold clears and keeps sub-second at 0
        cyc(0, 1, 0, 16'd77);
        cyc(0, 1, 15, 16'h0002);
        rd(15, v); check("R6 ctl2 hold readback", v, 16'h0002);
        cyc(1, 0, 0, 16'd0);
        cyc(0, 1, 0, 16'd33);
        compare_all("R7 hold");

        // R3: counting in run
        set_time(10, 20, 30, 2, 15, 6, 2023);
        rd(15, v); check("R6 ctl2 run readback", v, 16'h0009);
        for (int i = 0; i < 130; i++) cyc(1, 0, 0, 16'd0);
        compare_all("R3 run");
        check("R3 seconds advanced", {8'h00, bcd(m_sec)}, 16'h0031);

        // R4/R5/R8: year-end rollover with weekday 6 -> 0
        cyc(0, 1, 14, 16'h0000);
        day_corner("R4 R5 new year", 31, 12, 1999, 1, 1, 2000);
        check("R4 weekday wraps", {8'h00, bcd(m_wk)}, 16'h0000);
        rd(14, v); check("R8 carry flag", v, 16'h0080);

        // R9/R10: flag keep, enable, clear, set-wins
        cyc(0, 1, 14, 16'h0090);
        check("R10 irq asserted", {15'd0, carry_irq}, 16'd1);
        cyc(0, 1, 14, 16'h0010);
        check("R9 clear by zero", {15'd0, carry_irq}, 16'd0);
        cyc(0, 1, 0, 16'd127);
        cyc(1, 1, 14, 16'h0010);
        rd(14, v); check("R9 set wins over clear", v, 16'h0090);
        compare_all("R9 R10");

        // R5: month lengths and leap rules
        day_corner("R5 leap 2024 feb28", 28, 2, 2024, 29, 2, 2024);
        day_corner("R5 leap 2024 feb29", 29, 2, 2024, 1, 3, 2024);
        day_corner("R5 century 2100", 28, 2, 2100, 1, 3, 2100);
        day_corner("R5 div400 2000", 28, 2, 2000, 29, 2, 2000);
        day_corner("R5 april", 30, 4, 2023, 1, 5, 2023);
        day_corner("R5 january", 31, 1, 2023, 1, 2, 2023);
        day_corner("R5 century carry", 31, 12, 2099, 1, 1, 2100);

        // R11: write beats increment, no carry passed on
        set_time(8, 15, 59, 3, 10, 10, 2030);
        cyc(0, 1, 0, 16'd127);
        cyc(1, 1, 1, 16'h0030);
        compare_all("R11 write priority");
        check("R11 minutes unchanged", {8'h00, bcd(m_min)}, 16'h0015);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r, a, val;
            bit t;
            logic [15:0] d;
            r = int'($urandom % 100);
            t = ($urandom % 4) != 0;
            if (r < 4) begin
                a = int'($urandom % 8);
                case (a)
                    0: val = ($urandom % 2) ? 120 + int'($urandom % 8) : int'($urandom % 128);
                    1, 2: val = ($urandom % 2) ? 59 : int'($urandom % 60);
                    3: val = ($urandom % 2) ? 23 : int'($urandom % 24);
                    4: val = int'($urandom % 7);
                    5: val = ($urandom % 2) ? dim(m_mon, m_yr) : 1 + int'($urandom % dim(m_mon, m_yr));
                    6: val = ($urandom % 2) ? 12 : 1 + int'($urandom % 12);
                    default: val = 1900 + int'($urandom % 8000);
                endcase
                if (a == 0) d = 16'(val);
                else if (a == 7) d = yr_reg(val);
                else d = {8'h00, bcd(val)};
                cyc(t, 1, a, d);
            end else if (r == 4) begin
                cyc(t, 1, 14, 16'(($urandom % 2) * 128 + ($urandom % 2) * 16));
            end else if (r == 5) begin
                case ($urandom % 4)
                    0: d = 16'h0002;
                    1: d = 16'h0008;
                    default: d = 16'h0009;
                endcase
                cyc(t, 1, 15, d);
            end else begin
                cyc(t, 0, 0, 16'd0);
            end
            if (i % 4 == 0) compare_all("R3 R4 R5 R11 random");
        end
        compare_all("R2 final");

        done = 1'b1;
        report();
    end
endmodule